// File: doc/BRIEF.md
# Host-Driven Byte Boot Sequencer

This block sits on the host side of a target processor that boots from a byte-wide external memory. Instead of a memory device, the host plays that role. It holds the target in reset and parks it with an active-low bus request. It then hands over one boot byte at a time on a shared 8-bit data bus. Pacing comes from a request flip-flop with an asynchronous set. Every time the target pulls its active-low boot-memory select, the flip-flop asserts the request again and the target suspends. To release the target for exactly one fetch, the host clocks an inactive level into the flip-flop.

Boot bytes come from an upstream valid/ready stream. A byte count is captured at start. A controller state machine runs through these states:

- `HB_IDLE`: target held in reset.
- `HB_ARM`: request forced low.
- `HB_UNRST`: one settling cycle, reset still low.
- `HB_GETB`: wait for a stream byte.
- `HB_PRES`: byte on the bus, request released on the next edge.
- `HB_WAIT`: post-release wait.
- `HB_FINISH`: bus released, done pulse.
- `HB_RUN`: target running.

The transitions are:

- IDLE/RUN to ARM on a start with a non-zero count.
- ARM to UNRST, then UNRST to GETB.
- GETB to PRES when a byte is valid.
- PRES to WAIT.
- WAIT to GETB on expiry when bytes remain, or WAIT to FINISH on expiry after the last byte.
- FINISH to RUN.

The post-release wait is `WAIT_CYC` host cycles. It is never shorter than six target cycles, which is `6*HOST_PER_TGT` host cycles.

Top module: `hboot_seq`

## Requirements
- R1: While and after host reset, before any start, `tgt_rst_n`=0, `tgt_busreq_n`=0, `tgt_data_oe`=0, `s_ready`=0 and `done`=0.
- R2: A low on `tgt_bmem_n` drives `tgt_busreq_n` low at once, without waiting for a clock edge. The request stays low until the sequencer itself releases it.
- R3: A start sampled with a non-zero `byte_count` keeps `tgt_rst_n` low on the next two edges. `tgt_rst_n` rises on the second edge after the sampling edge, with `tgt_busreq_n` already low.
- R4: A start with `byte_count`=0 is ignored: target reset stays low and `s_ready` stays low.
- R5: A byte accepted on `s_valid && s_ready` is on `tgt_data_o` with `tgt_data_oe`=1 from the next cycle. `tgt_busreq_n` goes high one cycle after that.
- R6: After `tgt_busreq_n` rises, `s_ready` stays low for exactly `max(WAIT_CYC, 6*HOST_PER_TGT)` cycles before the next byte can be taken.
- R7: While the stream has no byte mid-sequence, `s_ready` stays high, `tgt_busreq_n` stays low, and the previous byte stays driven.
- R8: At the end of the wait after the last byte, `tgt_data_oe` drops and `done` pulses high for one cycle. `tgt_rst_n` stays high and `s_ready` stays low from then on.
- R9: A start with a non-zero count while the target runs pulls `tgt_rst_n` low on the sampling edge and repeats the whole sequence.
- R10: A start while a boot is in progress has no effect.
- R11: The target receives exactly `byte_count` bytes, in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Host reset, active low |
| start | input | 1 | Begin a boot sequence |
| byte_count | input | CNT_W | Number of boot bytes, sampled with start |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DW | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_busreq_n | output | 1 | Target bus request, active low |
| tgt_bmem_n | input | 1 | Target boot-memory select, active low |
| tgt_data_o | output | DW | Boot data bus value |
| tgt_data_oe | output | 1 | Boot data bus drive enable |
| done | output | 1 | One-cycle pulse when the bus is released |

## Verification
Boots are run with back-to-back stream bytes, with stream gaps inserted between bytes, and with a single-byte image. This separates the normal pacing from underflow holding and from the last-byte-is-first-byte corner. A behavioural target fetches on each released request and strobes boot-memory select. This shows whether the request re-arms asynchronously and whether the recorded byte order matches the stream. Zero-count starts, a start during a boot, and a start after a finished boot separate the ignore paths from the reboot path. The bench sets `WAIT_CYC` below the six-target-cycle floor, so the measured wait shows which of the two limits is in force.

// File: rtl/hboot_pkg.sv
package hboot_pkg;

    typedef enum logic [2:0] {
        HB_IDLE,
        HB_ARM,
        HB_UNRST,
        HB_GETB,
        HB_PRES,
        HB_WAIT,
        HB_FINISH,
        HB_RUN
    } hb_state_e;

    function automatic int unsigned hb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hboot_reqff.sv
// Bus request flip-flop: asynchronously set (output low) by the target's
// boot-memory strobe or host reset, cleared only by a clocked host load.
module hboot_reqff (
    input  logic clk,
    input  logic rst_n,
    input  logic bmem_n,
    input  logic ld,
    input  logic d,
    output logic req_n
);

    logic set_n;

    assign set_n = rst_n & bmem_n;

    always_ff @(posedge clk or negedge set_n) begin
        if (!set_n) begin
            req_n <= 1'b0;
        end else if (ld) begin
            req_n <= d;
        end
    end

    // R2: once asserted, only a host load can release the request
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !ld) |=> !req_n);

endmodule

// File: rtl/hboot_wait.sv
// Post-release wait counter: loaded with CYC-1, counts down to zero.
module hboot_wait #(
    parameter int unsigned CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC);
    localparam logic [CW-1:0] LOADV = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOADV;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R6: a new wait is only started after the previous one ran out
    reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

endmodule

// File: rtl/hboot_bcnt.sv
// Remaining-byte counter for the boot image.
module hboot_bcnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] total,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= total;
        end else if (dec) begin
            rem <= rem - 1'b1;
        end
    end

    assign last = (rem == CNT_W'(1));

    // R11: never count past the image length
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem != '0));

endmodule

// File: rtl/hboot_seq.sv
module hboot_seq #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned DW           = 8,
    parameter int unsigned HOST_PER_TGT = 2,
    parameter int unsigned TGT_MIN_CYC  = 6,
    parameter int unsigned WAIT_CYC     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             s_valid,
    input  logic [DW-1:0]    s_data,
    output logic             s_ready,
    output logic             tgt_rst_n,
    output logic             tgt_busreq_n,
    input  logic             tgt_bmem_n,
    output logic [DW-1:0]    tgt_data_o,
    output logic             tgt_data_oe,
    output logic             done
);

    import hboot_pkg::*;

    localparam int unsigned WAIT_EFF = hb_max(WAIT_CYC, TGT_MIN_CYC * HOST_PER_TGT);
    localparam int unsigned GW       = $clog2(WAIT_EFF + 1) + 1;

    hb_state_e state, state_nx;

    logic          go;
    logic          req_ld, req_d;
    logic          tmr_load, tmr_exp;
    logic          cnt_load, cnt_dec, cnt_last;
    logic          take;
    logic [DW-1:0] data_q;
    logic          rst_q, oe_q, done_q;

    assign go   = start && (byte_count != '0);
    assign take = (state == HB_GETB) && s_valid;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            HB_IDLE:   if (go) state_nx = HB_ARM;
            HB_ARM:    state_nx = HB_UNRST;
            HB_UNRST:  state_nx = HB_GETB;
            HB_GETB:   if (s_valid) state_nx = HB_PRES;
            HB_PRES:   state_nx = HB_WAIT;
            HB_WAIT:   if (tmr_exp) state_nx = cnt_last ? HB_FINISH : HB_GETB;
            HB_FINISH: state_nx = HB_RUN;
            HB_RUN:    if (go) state_nx = HB_ARM;
            default:   state_nx = HB_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            rst_q  <= !(state_nx inside {HB_IDLE, HB_ARM, HB_UNRST});
            oe_q   <= (state_nx inside {HB_PRES, HB_WAIT}) ||
                      ((state_nx == HB_GETB) && oe_q);
            done_q <= (state_nx == HB_FINISH);
            if (take) begin
                data_q <= s_data;
            end
        end
    end

    // ---------------- control strobes ----------------
    assign req_ld   = (state == HB_ARM) || (state == HB_PRES);
    assign req_d    = (state == HB_PRES);
    assign tmr_load = (state == HB_PRES);
    assign cnt_load = go && ((state == HB_IDLE) || (state == HB_RUN));
    assign cnt_dec  = (state == HB_WAIT) && tmr_exp;

    hboot_reqff u_reqff (
        .clk    (clk),
        .rst_n  (rst_n),
        .bmem_n (tgt_bmem_n),
        .ld     (req_ld),
        .d      (req_d),
        .req_n  (tgt_busreq_n)
    );

    hboot_wait #(.CYC(WAIT_EFF)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_exp)
    );

    hboot_bcnt #(.CNT_W(CNT_W)) u_bcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .total (byte_count),
        .dec   (cnt_dec),
        .last  (cnt_last)
    );

    assign s_ready     = (state == HB_GETB);
    assign tgt_rst_n   = rst_q;
    assign tgt_data_oe = oe_q;
    assign tgt_data_o  = data_q;
    assign done        = done_q;

    // ---------------- checker logic ----------------
    localparam logic [GW-1:0] WAIT_G = GW'(WAIT_EFF);

    logic          req_d1;
    logic [GW-1:0] rel_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_d1  <= 1'b0;
            rel_gap <= '0;
        end else begin
            req_d1 <= tgt_busreq_n;
            if (tgt_busreq_n && !req_d1) begin
                rel_gap <= GW'(1);
            end else if (rel_gap != '1) begin
                rel_gap <= rel_gap + 1'b1;
            end
        end
    end

    // R1
    quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n |-> !tgt_data_oe);

    // R3
    rst_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n) |-> !tgt_busreq_n);

    // R5
    byte_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (tgt_data_oe && (tgt_data_o == $past(s_data))));

    // R5
    grant_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_busreq_n) |-> tgt_data_oe);

    // R6
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && tgt_data_oe) |-> (rel_gap >= WAIT_G));

    // R8
    release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_data_oe) |-> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_hboot_seq.sv
module test_hboot_seq;

    localparam int HPT      = 2;
    localparam int WC       = 8;
    localparam int EXP_WAIT = (6 * HPT > WC) ? 6 * HPT : WC;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] byte_count;
    logic        s_valid;
    logic [7:0]  s_data;
    logic        s_ready;
    logic        tgt_rst_n;
    logic        tgt_busreq_n;
    logic        tgt_bmem_n = 1'b1;
    logic [7:0]  tgt_data_o;
    logic        tgt_data_oe;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] exp_b [0:15];
    logic [7:0] got   [0:15];
    int         fcnt  = 0;
    int         exp_n = 0;
    bit         oe_bad = 1'b0;

    always #5 clk = ~clk;

    hboot_seq #(
        .CNT_W(16), .DW(8), .HOST_PER_TGT(HPT), .TGT_MIN_CYC(6), .WAIT_CYC(WC)
    ) i_hboot_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .byte_count   (byte_count),
        .s_valid      (s_valid),
        .s_data       (s_data),
        .s_ready      (s_ready),
        .tgt_rst_n    (tgt_rst_n),
        .tgt_busreq_n (tgt_busreq_n),
        .tgt_bmem_n   (tgt_bmem_n),
        .tgt_data_o   (tgt_data_o),
        .tgt_data_oe  (tgt_data_oe),
        .done         (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural target: fetches one byte each time the request is released.
    initial begin
        int phase = 0;
        int dly   = 0;
        forever begin
            @(negedge clk);
            if (!tgt_rst_n) begin
                phase = 0;
                fcnt  = 0;
                tgt_bmem_n = 1'b1;
            end else begin
                case (phase)
                    0: if (tgt_busreq_n && fcnt < exp_n) begin dly = 2; phase = 1; end
                    1: begin
                        dly--;
                        if (dly == 0) begin
                            tgt_bmem_n = 1'b0;
                            got[fcnt] = tgt_data_o;
                            if (!tgt_data_oe) oe_bad = 1'b1;
                            fcnt++;
                            phase = 2;
                        end
                    end
                    2: begin tgt_bmem_n = 1'b1; phase = 3; end
                    default: if (!tgt_busreq_n) phase = 0;
                endcase
            end
        end
    end

    // R2: asynchronous re-arm, seen well before the next rising clock edge
    initial begin
        forever begin
            @(negedge tgt_bmem_n);
            #1;
            chk("R2 async request on strobe", int'(tgt_busreq_n), 0);
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    task automatic t_reset();
        chk("R1 rst_n in reset", int'(tgt_rst_n), 0);
        chk("R1 oe in reset", int'(tgt_data_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rst_n after reset", int'(tgt_rst_n), 0);
        chk("R1 busreq after reset", int'(tgt_busreq_n), 0);
        chk("R1 oe after reset", int'(tgt_data_oe), 0);
        chk("R1 s_ready after reset", int'(s_ready), 0);
        chk("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_zero_start();
        byte_count = 16'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R4 zero count keeps reset", int'(tgt_rst_n), 0);
            chk("R4 zero count no ready", int'(s_ready), 0);
        end
    endtask

    task automatic t_boot(input int n, input int gap, input bit poke, input int seed);
        for (int j = 0; j < n; j++) exp_b[j] = 8'(seed + 37 * j + 8'h3C);
        exp_n = n;
        oe_bad = 1'b0;
        byte_count = 16'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3/R9 reset low on start edge", int'(tgt_rst_n), 0);
        @(negedge clk);
        chk("R3 reset still low", int'(tgt_rst_n), 0);
        @(negedge clk);
        chk("R3 reset released", int'(tgt_rst_n), 1);
        chk("R3 request held low at release", int'(tgt_busreq_n), 0);
        if (poke) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk("R10 busy start no reset", int'(tgt_rst_n), 1);
            chk("R10 busy start keeps ready", int'(s_ready), 1);
        end
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                for (int g = 0; g < gap; g++) begin
                    chk("R7 underflow ready", int'(s_ready), 1);
                    chk("R7 underflow request low", int'(tgt_busreq_n), 0);
                    chk("R7 underflow bus held", int'(tgt_data_o), int'(exp_b[i-1]));
                    @(negedge clk);
                end
            end
            s_valid = 1'b1;
            s_data  = exp_b[i];
            while (!s_ready) @(negedge clk);
            @(negedge clk);
            s_valid = 1'b0;
            chk("R5 bus enabled", int'(tgt_data_oe), 1);
            chk("R5 byte on bus", int'(tgt_data_o), int'(exp_b[i]));
            @(negedge clk);
            chk("R5 request released", int'(tgt_busreq_n), 1);
            begin
                int k = 0;
                while (!s_ready && !done && k < 200) begin
                    @(negedge clk);
                    k++;
                end
                chk("R6 wait length", k, EXP_WAIT);
            end
            chk("R2 request re-armed by strobe", int'(tgt_busreq_n), 0);
            if (i == n - 1) begin
                chk("R8 done pulse", int'(done), 1);
                chk("R8 bus released", int'(tgt_data_oe), 0);
                chk("R8 target running", int'(tgt_rst_n), 1);
                chk("R8 no ready at end", int'(s_ready), 0);
                @(negedge clk);
                chk("R8 done one cycle", int'(done), 0);
            end
        end
        repeat (3) @(negedge clk);
        chk("R11 byte count fetched", fcnt, n);
        for (int j = 0; j < n; j++) chk("R11 byte order", int'(got[j]), int'(exp_b[j]));
        chk("R5 bus driven at fetch", int'(oe_bad), 0);
        chk("R8 stays running", int'(tgt_rst_n), 1);
        chk("R8 bus stays released", int'(tgt_data_oe), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        byte_count = 16'd0;
        s_valid = 1'b0;
        s_data = 8'd0;
        repeat (3) @(negedge clk);
        t_reset();
        t_zero_start();
        t_boot(4, 0, 1'b0, 1);
        t_boot(3, 2, 1'b1, 90);
        t_boot(1, 0, 1'b0, 200);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule